// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The block is the descriptor-handling half of a network transmitter. Software places 16-byte descriptors in a circular ring in memory. It programs the ring's base address and byte length through a small register port, then moves a tail index forward to hand entries to hardware. The engine owns every entry from its head index up to, but not including, the tail.

It works on one entry at a time. It reads the entry over a single-beat 128-bit memory read port and decodes it. It then offers the buffer address, length, command byte, checksum fields and special field on a packet-request port, and waits for the transmitter to signal completion. If the entry asked for a report, or if report-all mode is on, the engine writes a status byte back into the entry's status slot. It then advances the head, wrapping at the end of the ring. It also raises interrupt causes for a written-back entry and for the ring running dry.

Register indices on `reg_addr` are as follows:

| Index | Register |
|-------|----------|
| 0 | Control: bit1 run enable, bit0 report-all |
| 1 | Base address, low word |
| 2 | Base address, high word |
| 3 | Ring length in bytes |
| 4 | Head index |
| 5 | Tail index |
| 6 | Cause: bit0 written back, bit1 ring empty; reading it clears it |
| 7 | Interrupt mask, two bits |

Register reads are combinational on `reg_rdata` while `reg_rd` is high. Writes take effect at the clock edge.

Top module: `txring_engine`

## Requirements
- R1: After reset the following hold: head, tail, cause and mask (indices 4, 5, 6, 7) read 0; length (index 3) reads 128; `mem_rd_req`, `pkt_valid`, `mem_wr_req` and `irq` are low.
- R2: The engine starts reading an entry only when control bit1 is 1 and head differs from tail. The read address is base + head*16. With control bit1 at 0, no read is issued and the head does not move.
- R3: A fetched entry is decoded little-endian: bytes 0–7 give `pkt_addr`, bytes 8–9 give `pkt_len` and byte 11 gives `pkt_cmd`. `pkt_valid` and these fields hold steady until `pkt_done`.
- R4: After `pkt_done`, a status byte is written when command bit3 is set or control bit0 is set. The write goes to base + head*16 + 12, and its value has bit0 = 1, bit1 = `pkt_status[0]`, bit2 = `pkt_status[1]` and the other bits 0. Otherwise no write is issued.
- R5: After each entry is finished, the head advances by one and wraps to 0 when it reaches length/16.
- R6: A finished write-back sets cause bit0. An advance that makes head equal tail sets cause bit1.
- R7: A read of index 6 returns the cause value from before the read and clears it. A cause bit set in the same cycle as that read survives the read.
- R8: `irq` is high exactly when some cause bit is set whose mask bit (index 7) is also set.
- R9: Base and length writes are ignored while control bit1 is 1 or an entry is in flight. A length write below 128, or one that is not a multiple of 16, is also ignored. An accepted length write sets head and tail to 0.
- R10: A tail write with a value of at least length/16 is ignored. A head write is ignored while control bit1 is 1 or an entry is in flight.
- R11: An entry whose command bit5 is set is never presented on the packet port and gets no write-back. The head still advances past it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| mem_rd_req | output | 1 | Entry read request, held until served |
| mem_rd_addr | output | 64 | Entry byte address |
| mem_rd_valid | input | 1 | Entry data valid, one cycle |
| mem_rd_data | input | 128 | Entry contents, byte 0 in bits 7:0 |
| pkt_valid | output | 1 | Packet request valid |
| pkt_addr | output | 64 | Buffer address |
| pkt_len | output | 16 | Buffer length in bytes |
| pkt_cmd | output | 8 | Command byte |
| pkt_cso | output | 8 | Checksum offset byte |
| pkt_css | output | 8 | Checksum start byte |
| pkt_special | output | 16 | Special field |
| pkt_done | input | 1 | Packet finished, one cycle |
| pkt_status | input | 2 | bit0 excess collisions, bit1 late collision |
| mem_wr_req | output | 1 | Status write request, held until acknowledged |
| mem_wr_addr | output | 64 | Status byte address |
| mem_wr_data | output | 8 | Status byte value |
| mem_wr_ack | input | 1 | Status write accepted, one cycle |
| irq | output | 1 | Masked interrupt request |

## Verification
Software's clear-on-read of the cause register can land in the same cycle in which the engine finishes an entry and sets a cause bit. The bench provokes this by holding back the packet completion and raising `pkt_done` together with a cause read on the same cycle, on an entry whose finish empties the ring. It then checks that the read returned the old, cleared value and that a later read still finds the ring-empty bit. The mask is then switched between the two cause bits to confirm that `irq` follows only the unmasked one.

// File: rtl/txring_pkg.sv
package txring_pkg;

  // register indices
  localparam int RA_CTRL    = 0;
  localparam int RA_BASE_LO = 1;
  localparam int RA_BASE_HI = 2;
  localparam int RA_LEN     = 3;
  localparam int RA_HEAD    = 4;
  localparam int RA_TAIL    = 5;
  localparam int RA_CAUSE   = 6;
  localparam int RA_MASK    = 7;

  // control bits
  localparam int CTRL_GRAN = 0;
  localparam int CTRL_EN   = 1;

  // command byte bits
  localparam int CMD_RS   = 3;
  localparam int CMD_DEXT = 5;

  // cause bits
  localparam int CAUSE_WB    = 0;
  localparam int CAUSE_EMPTY = 1;

  localparam int DESC_BYTES = 16;
  localparam int STAT_OFS   = 12;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_PKT, ST_WB} seq_state_e;

  // entry layout, highest byte first so that byte 0 lands in bits 7:0
  typedef struct packed {
    logic [15:0] special;
    logic [7:0]  css;
    logic [7:0]  status;
    logic [7:0]  cmd;
    logic [7:0]  cso;
    logic [15:0] len;
    logic [63:0] addr;
  } tx_desc_t;

  function automatic logic [31:0] next_index(input logic [31:0] idx, input logic [31:0] n);
    return (idx + 32'd1 >= n) ? 32'd0 : idx + 32'd1;
  endfunction

  function automatic logic [63:0] desc_addr(input logic [63:0] base, input logic [31:0] idx);
    return base + {28'd0, idx, 4'd0};
  endfunction

  function automatic logic len_legal(input logic [31:0] w, input int unsigned min_len,
                                     input int unsigned len_w);
    return (w[3:0] == 4'd0) && (w >= min_len) && ((w >> len_w) == 32'd0);
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] coll);
    return {5'd0, coll, 1'b1};
  endfunction

endpackage

// File: rtl/txring_regs.sv
module txring_regs
  import txring_pkg::*;
#(
  parameter int LEN_W   = 20,
  parameter int MIN_LEN = 128,
  parameter int RA_W    = 3,
  localparam int IDX_W  = LEN_W - 4,
  localparam int NREG   = 1 << RA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             eng_busy,
  input  logic             retire,
  input  logic             wrote_back,
  output logic             en,
  output logic             gran,
  output logic [63:0]      base,
  output logic [IDX_W-1:0] entries,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [1:0]       cause,
  output logic [1:0]       mask,
  output logic             irq
);

  logic             en_q, gran_q;
  logic [63:0]      base_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] head_q, tail_q, head_step;
  logic [1:0]       cause_q, mask_q, cause_set, cause_clr;
  logic [NREG-1:0]  wr_sel;
  logic             cfg_open, idx_fits, rd_cause, len_ok;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign wr_sel[i] = reg_wr && (reg_addr == RA_W'(i));
  end

  assign entries   = len_q[LEN_W-1:4];
  assign cfg_open  = !en_q && !eng_busy;
  assign idx_fits  = reg_wdata < 32'(entries);
  assign len_ok    = len_legal(reg_wdata, MIN_LEN, LEN_W);
  assign rd_cause  = reg_rd && (reg_addr == RA_W'(RA_CAUSE));
  assign head_step = IDX_W'(next_index(32'(head_q), 32'(entries)));

  always_comb begin
    cause_set = '0;
    cause_set[CAUSE_WB]    = wrote_back;
    cause_set[CAUSE_EMPTY] = retire && (head_step == tail_q);
    cause_clr = rd_cause ? 2'b11 : 2'b00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      gran_q  <= 1'b0;
      base_q  <= '0;
      len_q   <= LEN_W'(MIN_LEN);
      head_q  <= '0;
      tail_q  <= '0;
      cause_q <= '0;
      mask_q  <= '0;
    end else begin
      if (wr_sel[RA_CTRL]) begin
        en_q   <= reg_wdata[CTRL_EN];
        gran_q <= reg_wdata[CTRL_GRAN];
      end
      if (wr_sel[RA_BASE_LO] && cfg_open) base_q[31:0]  <= reg_wdata;
      if (wr_sel[RA_BASE_HI] && cfg_open) base_q[63:32] <= reg_wdata;
      if (wr_sel[RA_MASK]) mask_q <= reg_wdata[1:0];
      if (wr_sel[RA_TAIL] && idx_fits) tail_q <= IDX_W'(reg_wdata);
      if (wr_sel[RA_HEAD] && cfg_open && idx_fits) head_q <= IDX_W'(reg_wdata);
      if (wr_sel[RA_LEN] && cfg_open && len_ok) begin
        len_q  <= LEN_W'(reg_wdata);
        head_q <= '0;
        tail_q <= '0;
      end
      if (retire) head_q <= head_step;
      cause_q <= (cause_q & ~cause_clr) | cause_set;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_W'(RA_CTRL):    reg_rdata = {30'd0, en_q, gran_q};
      RA_W'(RA_BASE_LO): reg_rdata = base_q[31:0];
      RA_W'(RA_BASE_HI): reg_rdata = base_q[63:32];
      RA_W'(RA_LEN):     reg_rdata = 32'(len_q);
      RA_W'(RA_HEAD):    reg_rdata = 32'(head_q);
      RA_W'(RA_TAIL):    reg_rdata = 32'(tail_q);
      RA_W'(RA_CAUSE):   reg_rdata = {30'd0, cause_q};
      RA_W'(RA_MASK):    reg_rdata = {30'd0, mask_q};
      default:           reg_rdata = '0;
    endcase
  end

  assign en    = en_q;
  assign gran  = gran_q;
  assign base  = base_q;
  assign head  = head_q;
  assign tail  = tail_q;
  assign cause = cause_q;
  assign mask  = mask_q;
  assign irq   = |(cause_q & mask_q);

endmodule

// File: rtl/txring_seq.sv
module txring_seq
  import txring_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             gran,
  input  logic [63:0]      base,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] tail,
  output logic             mem_rd_req,
  output logic [63:0]      mem_rd_addr,
  input  logic             mem_rd_valid,
  input  logic [127:0]     mem_rd_data,
  output logic             pkt_valid,
  output logic [63:0]      pkt_addr,
  output logic [15:0]      pkt_len,
  output logic [7:0]       pkt_cmd,
  output logic [7:0]       pkt_cso,
  output logic [7:0]       pkt_css,
  output logic [15:0]      pkt_special,
  input  logic             pkt_done,
  input  logic [1:0]       pkt_status,
  output logic             mem_wr_req,
  output logic [63:0]      mem_wr_addr,
  output logic [7:0]       mem_wr_data,
  input  logic             mem_wr_ack,
  output logic             busy,
  output logic             retire,
  output logic             wrote_back
);

  seq_state_e  state;
  tx_desc_t    desc_q, fetched;
  logic [7:0]  stat_q;
  logic [63:0] entry_base;
  logic        fetch_ext, need_wb, skip_ext, pkt_only;

  assign fetched    = tx_desc_t'(mem_rd_data);
  assign fetch_ext  = fetched.cmd[CMD_DEXT];
  assign need_wb    = desc_q.cmd[CMD_RS] | gran;
  assign entry_base = desc_addr(base, 32'(head));

  assign skip_ext   = (state == ST_FETCH) && mem_rd_valid && fetch_ext;
  assign pkt_only   = (state == ST_PKT) && pkt_done && !need_wb;
  assign wrote_back = (state == ST_WB) && mem_wr_ack;
  assign retire     = skip_ext || pkt_only || wrote_back;
  assign busy       = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      desc_q <= '0;
      stat_q <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (en && (head != tail)) state <= ST_FETCH;
        ST_FETCH: if (mem_rd_valid) begin
                    desc_q <= fetched;
                    state  <= fetch_ext ? ST_IDLE : ST_PKT;
                  end
        ST_PKT:   if (pkt_done) begin
                    stat_q <= status_byte(pkt_status);
                    state  <= need_wb ? ST_WB : ST_IDLE;
                  end
        ST_WB:    if (mem_wr_ack) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mem_rd_req  = (state == ST_FETCH);
  assign mem_rd_addr = entry_base;
  assign pkt_valid   = (state == ST_PKT);
  assign pkt_addr    = desc_q.addr;
  assign pkt_len     = desc_q.len;
  assign pkt_cmd     = desc_q.cmd;
  assign pkt_cso     = desc_q.cso;
  assign pkt_css     = desc_q.css;
  assign pkt_special = desc_q.special;
  assign mem_wr_req  = (state == ST_WB);
  assign mem_wr_addr = entry_base + 64'(STAT_OFS);
  assign mem_wr_data = stat_q;

endmodule

// File: rtl/txring_engine.sv
module txring_engine
  import txring_pkg::*;
#(
  parameter int LEN_W   = 20,
  parameter int MIN_LEN = 128,
  parameter int RA_W    = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RA_W-1:0] reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_rd_req,
  output logic [63:0]     mem_rd_addr,
  input  logic            mem_rd_valid,
  input  logic [127:0]    mem_rd_data,
  output logic            pkt_valid,
  output logic [63:0]     pkt_addr,
  output logic [15:0]     pkt_len,
  output logic [7:0]      pkt_cmd,
  output logic [7:0]      pkt_cso,
  output logic [7:0]      pkt_css,
  output logic [15:0]     pkt_special,
  input  logic            pkt_done,
  input  logic [1:0]      pkt_status,
  output logic            mem_wr_req,
  output logic [63:0]     mem_wr_addr,
  output logic [7:0]      mem_wr_data,
  input  logic            mem_wr_ack,
  output logic            irq
);

  localparam int IDX_W = LEN_W - 4;

  logic             en, gran, busy, retire, wrote_back;
  logic [63:0]      base;
  logic [IDX_W-1:0] entries, head, tail;
  logic [1:0]       cause, mask;

  txring_regs #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_busy(busy), .retire(retire), .wrote_back(wrote_back),
    .en(en), .gran(gran), .base(base), .entries(entries),
    .head(head), .tail(tail), .cause(cause), .mask(mask), .irq(irq)
  );

  txring_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(en), .gran(gran), .base(base), .head(head), .tail(tail),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .pkt_valid(pkt_valid), .pkt_addr(pkt_addr), .pkt_len(pkt_len),
    .pkt_cmd(pkt_cmd), .pkt_cso(pkt_cso), .pkt_css(pkt_css),
    .pkt_special(pkt_special), .pkt_done(pkt_done), .pkt_status(pkt_status),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .busy(busy), .retire(retire), .wrote_back(wrote_back)
  );

endmodule

// File: rtl/txring_chk.sv
module txring_chk #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [IDX_W-1:0] entries,
  input logic [IDX_W-1:0] head,
  input logic [IDX_W-1:0] tail,
  input logic             retire,
  input logic             wrote_back,
  input logic [1:0]       cause,
  input logic [1:0]       mask,
  input logic             irq,
  input logic             mem_rd_req,
  input logic             pkt_valid,
  input logic             pkt_done,
  input logic [63:0]      pkt_addr,
  input logic [15:0]      pkt_len,
  input logic             mem_wr_req,
  input logic [63:0]      mem_wr_addr,
  input logic [7:0]       mem_wr_data
);

  AST_FETCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd_req) |-> ($past(en) && ($past(head) != $past(tail)))) else $error("fetch"); // R2

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, pkt_valid, mem_wr_req})) else $error("phase"); // R3

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_done) |=> (pkt_valid && $stable(pkt_addr) && $stable(pkt_len))) else $error("hold"); // R3

  AST_WB_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> ((mem_wr_addr[3:0] == 4'hC) && mem_wr_data[0] && (mem_wr_data[7:3] == 5'd0))) else $error("wb"); // R4

  AST_HEAD_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    head < entries) else $error("head range"); // R5

  AST_HEAD_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (head != $past(head))) else $error("head step"); // R5

  AST_WB_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wrote_back |=> cause[0]) else $error("wb cause"); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 2'b00) |-> !irq) else $error("mask"); // R8

endmodule

bind txring_engine txring_chk #(.IDX_W(LEN_W - 4)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .entries(entries), .head(head), .tail(tail),
  .retire(retire), .wrote_back(wrote_back), .cause(cause), .mask(mask), .irq(irq),
  .mem_rd_req(mem_rd_req), .pkt_valid(pkt_valid), .pkt_done(pkt_done),
  .pkt_addr(pkt_addr), .pkt_len(pkt_len), .mem_wr_req(mem_wr_req),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/tb_txring_engine.sv
`timescale 1ns/1ps
module tb_txring_engine;

  localparam logic [63:0] BASE = 64'h0000_0003_0000_2000;
  localparam int ENTS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_rd_req, mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_addr;
  logic [127:0] mem_rd_data = '0;
  logic pkt_valid, pkt_done;
  logic [63:0] pkt_addr;
  logic [15:0] pkt_len, pkt_special;
  logic [7:0] pkt_cmd, pkt_cso, pkt_css;
  logic [1:0] pkt_status;
  logic mem_wr_req, mem_wr_ack = 1'b0;
  logic [63:0] mem_wr_addr;
  logic [7:0] mem_wr_data;
  logic irq;

  logic auto_done = 1'b0, man_done = 1'b0, manual = 1'b0;
  logic [1:0] auto_stat = '0;
  assign pkt_done   = manual ? man_done : auto_done;
  assign pkt_status = manual ? 2'b00 : auto_stat;

  always #4 clk = ~clk;

  txring_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .pkt_valid(pkt_valid), .pkt_addr(pkt_addr),
    .pkt_len(pkt_len), .pkt_cmd(pkt_cmd), .pkt_cso(pkt_cso), .pkt_css(pkt_css),
    .pkt_special(pkt_special), .pkt_done(pkt_done), .pkt_status(pkt_status),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [127:0] ring_mem [ENTS];
  int exp_idx = 0, cur_idx = 0;
  int rd_seen = 0, pkt_seen = 0, wb_seen = 0, exp_wb = 0;
  bit gran_b = 0;
  logic [7:0] exp_stat = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_desc(input logic [63:0] a, input logic [15:0] l,
                                           input logic [7:0] c, input logic [31:0] junk);
    return {junk[31:16], junk[15:8], 8'h00, c, junk[7:0], l, a};
  endfunction

  function automatic logic [63:0] slot_addr(input int idx);
    return BASE + 64'(idx) * 64'd16;
  endfunction

  // memory read responder
  always @(negedge clk) begin
    if (mem_rd_valid) mem_rd_valid = 1'b0;
    else if (mem_rd_req && ($urandom % 3 == 0)) begin
      chk(mem_rd_addr == slot_addr(exp_idx), "R2 fetch address", mem_rd_addr, slot_addr(exp_idx));
      mem_rd_data  = ring_mem[exp_idx];
      mem_rd_valid = 1'b1;
      cur_idx = exp_idx;
      exp_idx = (exp_idx + 1) % ENTS;
      rd_seen++;
    end
  end

  // packet responder
  always @(negedge clk) begin
    if (auto_done) auto_done = 1'b0;
    else if (!manual && pkt_valid && ($urandom % 2 == 0)) begin
      logic [127:0] d;
      d = ring_mem[cur_idx];
      chk(pkt_addr == d[63:0], "R3 buffer address", pkt_addr, d[63:0]);
      chk(pkt_len == d[79:64], "R3 length", 64'(pkt_len), 64'(d[79:64]));
      chk(pkt_cmd == d[95:88], "R3 command", 64'(pkt_cmd), 64'(d[95:88]));
      auto_stat = 2'($urandom);
      exp_stat  = {5'd0, auto_stat, 1'b1};
      if (d[91] || gran_b) exp_wb++;
      pkt_seen++;
      auto_done = 1'b1;
    end
  end

  // status write responder
  always @(negedge clk) begin
    if (mem_wr_ack) mem_wr_ack = 1'b0;
    else if (mem_wr_req && ($urandom % 2 == 0)) begin
      chk(mem_wr_addr == slot_addr(cur_idx) + 64'd12, "R4 write-back address",
          mem_wr_addr, slot_addr(cur_idx) + 64'd12);
      chk(mem_wr_data == exp_stat, "R4 status value", 64'(mem_wr_data), 64'(exp_stat));
      ring_mem[cur_idx][103:96] = mem_wr_data;
      wb_seen++;
      mem_wr_ack = 1'b1;
    end
  end

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_head(input int target);
    logic [31:0] v;
    for (int i = 0; i < 4000; i++) begin
      reg_read(3'd4, v);
      if (v == 32'(target)) break;
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int p0, w0, r0, e0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < ENTS; i++)
      ring_mem[i] = mk_desc({$urandom, $urandom}, 16'($urandom), 8'($urandom) & 8'hDF, $urandom);
    ring_mem[0][91] = 1'b1;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!irq && !mem_rd_req && !pkt_valid && !mem_wr_req, "R1 outputs idle",
        {mem_rd_req, pkt_valid, mem_wr_req, irq}, 0);
    reg_read(3'd3, v); chk(v == 32'd128, "R1 length", v, 128);
    reg_read(3'd4, v); chk(v == 0, "R1 head", v, 0);
    reg_read(3'd5, v); chk(v == 0, "R1 tail", v, 0);
    reg_read(3'd6, v); chk(v == 0, "R1 cause", v, 0);
    reg_read(3'd7, v); chk(v == 0, "R1 mask", v, 0);

    // R9 length rules while disabled
    reg_write(3'd3, 32'd64);  reg_read(3'd3, v); chk(v == 32'd128, "R9 short length ignored", v, 128);
    reg_write(3'd3, 32'd200); reg_read(3'd3, v); chk(v == 32'd128, "R9 odd length ignored", v, 128);
    reg_write(3'd3, 32'd256); reg_read(3'd3, v); chk(v == 32'd256, "R9 length accepted", v, 256);
    reg_write(3'd1, BASE[31:0]);
    reg_write(3'd2, BASE[63:32]);
    reg_write(3'd7, 32'd3);

    // main run: six entries
    reg_write(3'd5, 32'd6);
    reg_write(3'd0, 32'd2);
    wait_head(6);
    reg_read(3'd4, v); chk(v == 6, "R5 head after run", v, 6);
    chk(pkt_seen == 6, "R3 packets presented", 64'(pkt_seen), 6);
    chk(wb_seen == exp_wb, "R4 write-back count", 64'(wb_seen), 64'(exp_wb));
    chk(irq == 1'b1, "R8 irq with causes set", 64'(irq), 1);
    reg_read(3'd6, v); chk(v == 32'd3, "R6 cause after run", v, 3);
    reg_read(3'd6, v); chk(v == 0, "R7 cause cleared by read", v, 0);
    chk(irq == 1'b0, "R8 irq after clear", 64'(irq), 0);

    // R9 writes while enabled ignored
    reg_write(3'd3, 32'd128); reg_read(3'd3, v); chk(v == 32'd256, "R9 length write while enabled", v, 256);
    reg_write(3'd1, 32'h0000_5000); reg_read(3'd1, v); chk(v == BASE[31:0], "R9 base write while enabled", v, BASE[31:0]);

    // R10 pointer write rules
    reg_write(3'd5, 32'd20); reg_read(3'd5, v); chk(v == 6, "R10 tail out of ring ignored", v, 6);
    reg_write(3'd4, 32'd2);  reg_read(3'd4, v); chk(v == 6, "R10 head write while enabled", v, 6);

    // R5 wraparound: 6..15, 0..2
    p0 = pkt_seen;
    reg_write(3'd5, 32'd3);
    wait_head(3);
    reg_read(3'd4, v); chk(v == 3, "R5 head after wrap", v, 3);
    chk(pkt_seen - p0 == 13, "R5 entries across wrap", 64'(pkt_seen - p0), 13);

    // R4 report-all mode forces write-back
    for (int i = 3; i < 7; i++) ring_mem[i][91] = 1'b0;
    gran_b = 1;
    reg_write(3'd0, 32'd3);
    w0 = wb_seen;
    reg_write(3'd5, 32'd7);
    wait_head(7);
    chk(wb_seen - w0 == 4, "R4 report-all write-backs", 64'(wb_seen - w0), 4);
    reg_write(3'd0, 32'd2);
    gran_b = 0;

    // R11 extension entry skipped
    ring_mem[7][93] = 1'b1;
    ring_mem[7][91] = 1'b1;
    p0 = pkt_seen; w0 = wb_seen;
    reg_write(3'd5, 32'd8);
    wait_head(8);
    reg_read(3'd4, v); chk(v == 8, "R11 head moves past extension entry", v, 8);
    chk(pkt_seen == p0 && wb_seen == w0, "R11 no packet and no write-back",
        64'((pkt_seen - p0) + (wb_seen - w0)), 0);

    // R2 disabled engine does not fetch
    reg_write(3'd0, 32'd0);
    r0 = rd_seen;
    reg_write(3'd5, 32'd10);
    repeat (30) @(negedge clk);
    chk(rd_seen == r0 && !mem_rd_req, "R2 no fetch while disabled", 64'(rd_seen - r0), 0);
    reg_read(3'd4, v); chk(v == 8, "R2 head held while disabled", v, 8);

    // R7 clear-on-read colliding with a cause set
    ring_mem[8][91] = 1'b0; ring_mem[9][91] = 1'b0;
    reg_read(3'd6, v);
    reg_write(3'd7, 32'd1);
    manual = 1'b1;
    reg_write(3'd0, 32'd2);
    e0 = 0;
    @(negedge clk);
    while (!pkt_valid && e0 < 500) begin @(negedge clk); e0++; end
    man_done = 1'b1;
    @(negedge clk); man_done = 1'b0;
    e0 = 0;
    while (!pkt_valid && e0 < 500) begin @(negedge clk); e0++; end
    man_done = 1'b1; reg_rd = 1'b1; reg_addr = 3'd6;
    #1 v = reg_rdata;
    chk(v == 0, "R7 read in collision cycle returns old value", v, 0);
    @(negedge clk); man_done = 1'b0; reg_rd = 1'b0;
    manual = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 masked empty cause", 64'(irq), 0);
    reg_write(3'd7, 32'd2);
    chk(irq == 1'b1, "R8 unmasked empty cause", 64'(irq), 1);
    reg_read(3'd6, v); chk(v == 32'd2, "R7 set survives colliding read", v, 2);
    reg_read(3'd4, v); chk(v == 10, "R6 head reached tail", v, 10);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule